// File: doc/BRIEF.md
# Dual-Type Reset Sequencing Controller

This block decides which kind of reset the chip is in and drives the reset lines of three domains: the core, the general peripherals, and a protected domain that holds the bus controller and the I/O ports. A main reset pin always starts a power-on reset. A second, manual reset pin starts a lighter reset only while software has enabled it and the main pin is high. A watchdog request can also start either kind. Both pins are synchronised and must stay low for a minimum number of clock cycles before they are accepted. Shorter glitches are dropped.

Once the reset has been released, the controller starts the core. It first lets the domain resets go. It then asks a simple memory port for the reset vector and waits for the answer. It hands the fetched address to the core as its start address, and only then raises the run signal. The initial trace flag and interrupt-mask flags are presented to the core at that point. A two-bit cause register records why the last reset happened.

An asynchronous cold-start input from the supply monitor puts the whole block into a power-on reset. It stays there until the synchronised main pin reads high.

Top module: `rstseq_ctrl`

## Requirements
- R1: A main pin held low for at least QUAL_CYCLES synchronised cycles starts a power-on reset whatever the manual pin does. A power-on reset asserts `core_rst`, `periph_rst` and `prot_rst`, and sets `rst_cause` to 2'b00.
- R2: A manual pin held low for at least QUAL_CYCLES cycles, while the main pin is high and `man_en` is 1, starts a manual reset. A manual reset asserts `core_rst` and `periph_rst` but leaves `prot_rst` low, and sets `rst_cause` to 2'b01. While `man_en` is 0 the manual pin has no effect.
- R3: Each pin passes through a two-flop synchroniser. A low pulse shorter than QUAL_CYCLES (default 20) clock cycles is ignored. A pulse of L ≥ QUAL_CYCLES cycles keeps `core_rst` high for max(1, L−QUAL_CYCLES) cycles.
- R4: A one-cycle `wdt_req` during running or vector fetch holds the reset for exactly QUAL_CYCLES cycles. With `wdt_man_type`=0 it resets like R1 and sets `rst_cause` 2'b10. With `wdt_man_type`=1 it resets like R2 and sets `rst_cause` 2'b11.
- R5: After release, all domain resets are low. `vec_req` stays high with `vec_addr`=VEC_ADDR until `vec_valid`. In the cycle after `vec_valid`, `start_pc` equals the `vec_data` that was presented and `core_run` is 1.
- R6: When `core_run` rises, `exr_t` is 0 and `exr_i` and `ccr_i` are both 1.
- R7: `man_en` is written by `cfg_we`/`cfg_man_en`. Every power-on-type reset (pin, watchdog or cold start) clears it. A manual-type reset leaves it unchanged.
- R8: While `cold_n` is low, the block holds all three domain resets, `core_run`=0, `vec_req`=0, `man_en`=0 and `rst_cause`=2'b00. After `cold_n` rises it stays in reset until the synchronised main pin is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock |
| cold_n | input | 1 | Asynchronous cold start from the supply monitor, active low |
| main_rst_n | input | 1 | Main reset pin, active low, asynchronous |
| man_rst_n | input | 1 | Manual reset pin, active low, asynchronous |
| wdt_req | input | 1 | One-cycle watchdog reset request |
| wdt_man_type | input | 1 | Watchdog reset type: 0 power-on, 1 manual |
| cfg_we | input | 1 | Write strobe for the manual-enable bit |
| cfg_man_en | input | 1 | Value written into the manual-enable bit |
| vec_valid | input | 1 | Reset vector returned by memory |
| vec_data | input | ADDR_W | Fetched reset vector |
| core_rst | output | 1 | Core domain reset, active high |
| periph_rst | output | 1 | General peripheral domain reset, active high |
| prot_rst | output | 1 | Bus-controller and I/O-port domain reset, active high |
| vec_req | output | 1 | Vector read request |
| vec_addr | output | ADDR_W | Address of the reset vector |
| start_pc | output | ADDR_W | Start address handed to the core |
| core_run | output | 1 | Core may execute from `start_pc` |
| exr_t | output | 1 | Initial trace flag |
| exr_i | output | 1 | Initial interrupt mask, extended register |
| ccr_i | output | 1 | Initial interrupt mask, main condition register |
| man_en | output | 1 | Manual-reset enable bit |
| rst_cause | output | 2 | Cause of the last reset |

## Verification
The hardest case to reach is the exact edge of pulse qualification through the synchroniser. A pulse of QUAL_CYCLES−1 cycles must leave the core untouched. One cycle longer must give a reset that lasts only a single cycle. The bench sweeps the low time of each pin from 1 to QUAL_CYCLES+3 cycles, driven on falling clock edges. It counts the cycles in which `core_rst` is high and compares that count with the arithmetic expectation. For the manual sweeps, the enable bit is written back after each power-on reset so that the manual path is actually armed.

// File: rtl/rstseq_ctrl.sv
module rstseq_ctrl #(
  parameter int QUAL_CYCLES = 20,
  parameter int ADDR_W = 24,
  parameter logic [ADDR_W-1:0] VEC_ADDR = '0
) (
  input  logic              clk,
  input  logic              cold_n,
  input  logic              main_rst_n,
  input  logic              man_rst_n,
  input  logic              wdt_req,
  input  logic              wdt_man_type,
  input  logic              cfg_we,
  input  logic              cfg_man_en,
  input  logic              vec_valid,
  input  logic [ADDR_W-1:0] vec_data,
  output logic              core_rst,
  output logic              periph_rst,
  output logic              prot_rst,
  output logic              vec_req,
  output logic [ADDR_W-1:0] vec_addr,
  output logic [ADDR_W-1:0] start_pc,
  output logic              core_run,
  output logic              exr_t,
  output logic              exr_i,
  output logic              ccr_i,
  output logic              man_en,
  output logic [1:0]        rst_cause
);
  localparam int CW = $clog2(QUAL_CYCLES + 1);
  localparam logic [CW-1:0] QMAX = CW'(QUAL_CYCLES);
  localparam logic [1:0] C_POR = 2'b00, C_MAN = 2'b01, C_WPOR = 2'b10, C_WMAN = 2'b11;

  typedef enum logic [1:0] {S_HOLD, S_FETCH, S_RUN} st_t;

  st_t state, n_state;
  logic is_por, n_por, from_wdt, n_wdt, pc_load, por_entry;
  logic [1:0] n_cause;
  logic m1, main_s, r1, man_s;
  logic [CW-1:0] por_cnt, man_cnt, hold_cnt;
  logic por_q, man_q;

  always_ff @(posedge clk or negedge cold_n)
    if (!cold_n) begin
      m1 <= 1'b0; main_s <= 1'b0; r1 <= 1'b1; man_s <= 1'b1;
    end else begin
      m1 <= main_rst_n; main_s <= m1; r1 <= man_rst_n; man_s <= r1;
    end

  always_ff @(posedge clk or negedge cold_n)
    if (!cold_n) begin
      por_cnt <= '0; man_cnt <= '0;
    end else begin
      if (main_s) por_cnt <= '0;
      else if (por_cnt != QMAX) por_cnt <= por_cnt + 1'b1;
      if (man_s) man_cnt <= '0;
      else if (man_cnt != QMAX) man_cnt <= man_cnt + 1'b1;
    end

  assign por_q = (por_cnt == QMAX);
  assign man_q = (man_cnt == QMAX) && main_s && man_en;

  always_comb begin
    n_state = state; n_por = is_por; n_wdt = from_wdt; n_cause = rst_cause;
    pc_load = 1'b0; por_entry = 1'b0;
    if (state == S_HOLD) begin
      if (!is_por && por_q) begin
        n_por = 1'b1; n_wdt = 1'b0; n_cause = C_POR; por_entry = 1'b1;
      end else if (from_wdt ? (hold_cnt == QMAX - 1'b1) : (is_por ? main_s : man_s))
        n_state = S_FETCH;
    end else if (por_q) begin
      n_state = S_HOLD; n_por = 1'b1; n_wdt = 1'b0; n_cause = C_POR; por_entry = 1'b1;
    end else if (man_q) begin
      n_state = S_HOLD; n_por = 1'b0; n_wdt = 1'b0; n_cause = C_MAN;
    end else if (wdt_req) begin
      n_state = S_HOLD; n_por = !wdt_man_type; n_wdt = 1'b1;
      n_cause = wdt_man_type ? C_WMAN : C_WPOR; por_entry = !wdt_man_type;
    end else if (state == S_FETCH && vec_valid) begin
      n_state = S_RUN; pc_load = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge cold_n)
    if (!cold_n) begin
      state <= S_HOLD; is_por <= 1'b1; from_wdt <= 1'b0; rst_cause <= C_POR;
      start_pc <= '0;
    end else begin
      state <= n_state; is_por <= n_por; from_wdt <= n_wdt; rst_cause <= n_cause;
      if (pc_load) start_pc <= vec_data;
    end

  always_ff @(posedge clk or negedge cold_n)
    if (!cold_n) hold_cnt <= '0;
    else if (state != S_HOLD || !from_wdt) hold_cnt <= '0;
    else hold_cnt <= hold_cnt + 1'b1;

  always_ff @(posedge clk or negedge cold_n)
    if (!cold_n) man_en <= 1'b0;
    else if (por_entry) man_en <= 1'b0;
    else if (cfg_we && !(state == S_HOLD && is_por)) man_en <= cfg_man_en;

  always_ff @(posedge clk or negedge cold_n)
    if (!cold_n) begin
      exr_t <= 1'b0; exr_i <= 1'b0; ccr_i <= 1'b0;
    end else if (state == S_HOLD) begin
      exr_t <= 1'b0; exr_i <= 1'b1; ccr_i <= 1'b1;
    end

  assign core_rst   = (state == S_HOLD);
  assign periph_rst = (state == S_HOLD);
  assign prot_rst   = (state == S_HOLD) && is_por;
  assign vec_req    = (state == S_FETCH);
  assign vec_addr   = VEC_ADDR;
  assign core_run   = (state == S_RUN);

  assert_por_all_domains_R1: assert property (@(posedge clk) disable iff (!cold_n)
    prot_rst |-> core_rst && periph_rst);
  assert_manual_spares_prot_R2: assert property (@(posedge clk) disable iff (!cold_n)
    core_rst && rst_cause[0] |-> !prot_rst);
  assert_pin_qualified_R3: assert property (@(posedge clk) disable iff (!cold_n)
    $rose(core_rst) && rst_cause == C_POR |-> $past(por_cnt == QMAX));
  assert_wdt_origin_R4: assert property (@(posedge clk) disable iff (!cold_n)
    $rose(core_rst) && rst_cause[1] |-> $past(wdt_req));
  assert_req_held_R5: assert property (@(posedge clk) disable iff (!cold_n)
    vec_req && !vec_valid |=> vec_req || core_rst);
  assert_pc_from_vector_R5: assert property (@(posedge clk) disable iff (!cold_n)
    $rose(core_run) |-> $past(vec_valid) && $past(vec_req) && start_pc == $past(vec_data));
  assert_start_flags_R6: assert property (@(posedge clk) disable iff (!cold_n)
    $rose(core_run) |-> !exr_t && exr_i && ccr_i);
  assert_enable_cleared_R7: assert property (@(posedge clk) disable iff (!cold_n)
    core_rst && !rst_cause[0] |-> !man_en);
endmodule

// File: tb/rstseq_ctrl_tb.sv
`timescale 1ns/1ps
module rstseq_ctrl_tb;
  localparam int Q = 20;
  localparam int AW = 24;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic cold_n, main_rst_n, man_rst_n, wdt_req, wdt_man_type, cfg_we, cfg_man_en, vec_valid;
  logic [AW-1:0] vec_data;
  logic core_rst, periph_rst, prot_rst, vec_req, core_run, exr_t, exr_i, ccr_i, man_en;
  logic [AW-1:0] vec_addr, start_pc;
  logic [1:0] rst_cause;

  rstseq_ctrl u_dut (.clk(clk), .cold_n(cold_n), .main_rst_n(main_rst_n), .man_rst_n(man_rst_n),
    .wdt_req(wdt_req), .wdt_man_type(wdt_man_type), .cfg_we(cfg_we), .cfg_man_en(cfg_man_en),
    .vec_valid(vec_valid), .vec_data(vec_data), .core_rst(core_rst), .periph_rst(periph_rst),
    .prot_rst(prot_rst), .vec_req(vec_req), .vec_addr(vec_addr), .start_pc(start_pc),
    .core_run(core_run), .exr_t(exr_t), .exr_i(exr_i), .ccr_i(ccr_i), .man_en(man_en),
    .rst_cause(rst_cause));

  int checks = 0, failures = 0;
  bit saw_core, saw_prot, saw_per;
  int core_hi;
  logic [AW-1:0] next_vec = 24'h00_1000, last_vec = '0, seen_addr = '1;

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  initial forever begin
    @(negedge clk);
    if (core_rst) begin saw_core = 1; core_hi++; end
    if (prot_rst) saw_prot = 1;
    if (periph_rst) saw_per = 1;
  end

  initial begin
    vec_valid = 0; vec_data = '0;
    forever begin
      @(negedge clk);
      vec_valid = 0;
      if (vec_req) begin
        seen_addr = vec_addr; vec_data = next_vec; last_vec = next_vec;
        vec_valid = 1; next_vec = next_vec + 24'h01_3579;
      end
    end
  end

  initial begin
    #1_000_000;
    failures++; checks++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  task automatic clear_mon();
    @(negedge clk); #1;
    saw_core = 0; saw_prot = 0; saw_per = 0; core_hi = 0;
  endtask

  task automatic settle();
    for (int i = 0; i < 300 && !core_run; i++) @(negedge clk);
    #1;
    chk(core_run, "R5 core_run", core_run, 1);
    chk(start_pc == last_vec, "R5 start_pc", start_pc, last_vec);
    chk(seen_addr == '0, "R5 vec_addr", seen_addr, 0);
    chk(!exr_t && exr_i && ccr_i, "R6 flags", {exr_t, exr_i, ccr_i}, 3'b011);
    repeat (3) @(negedge clk);
  endtask

  task automatic write_en(bit v);
    @(negedge clk); cfg_we = 1; cfg_man_en = v;
    @(negedge clk); cfg_we = 0; #1;
    chk(man_en == v, "R7 enable write", man_en, v);
  endtask

  task automatic pulse(bit use_man, int len);
    @(negedge clk);
    if (use_man) man_rst_n = 0; else main_rst_n = 0;
    repeat (len) @(negedge clk);
    man_rst_n = 1; main_rst_n = 1;
  endtask

  task automatic fire_wdt(bit mtype);
    @(negedge clk); wdt_req = 1; wdt_man_type = mtype;
    @(negedge clk); wdt_req = 0;
  endtask

  initial begin
    cold_n = 0; main_rst_n = 0; man_rst_n = 1; wdt_req = 0; wdt_man_type = 0;
    cfg_we = 0; cfg_man_en = 0;
    repeat (3) @(negedge clk); #1;
    chk(core_rst && periph_rst && prot_rst, "R8 cold resets", {core_rst, periph_rst, prot_rst}, 3'b111);
    chk(!core_run && !vec_req, "R8 cold idle", {core_run, vec_req}, 0);
    chk(!man_en && rst_cause == 2'b00, "R8 cold status", {man_en, rst_cause}, 0);
    @(negedge clk); cold_n = 1;
    repeat (6) @(negedge clk); #1;
    chk(core_rst && prot_rst, "R8 held by main pin", {core_rst, prot_rst}, 3);
    main_rst_n = 1;
    settle();

    clear_mon(); pulse(1, 30); repeat (30) @(negedge clk); #1;
    chk(!saw_core && core_run, "R2 manual ignored when disabled", saw_core, 0);
    write_en(1);

    for (int len = 1; len <= Q + 3; len++) begin
      clear_mon(); pulse(0, len); repeat (30) @(negedge clk); #1;
      chk(saw_core == (len >= Q), "R3 main pulse", saw_core, len >= Q);
      if (len >= Q) begin
        chk(core_hi == ((len - Q) > 1 ? len - Q : 1), "R3 main hold length", core_hi,
            (len - Q) > 1 ? len - Q : 1);
        chk(saw_prot && saw_per, "R1 all domains", {saw_prot, saw_per}, 3);
        chk(rst_cause == 2'b00, "R1 cause", rst_cause, 0);
        chk(!man_en, "R7 cleared by power-on", man_en, 0);
        settle(); write_en(1);
      end
    end

    for (int len = 1; len <= Q + 3; len++) begin
      clear_mon(); pulse(1, len); repeat (30) @(negedge clk); #1;
      chk(saw_core == (len >= Q), "R3 manual pulse", saw_core, len >= Q);
      if (len >= Q) begin
        chk(core_hi == ((len - Q) > 1 ? len - Q : 1), "R3 manual hold length", core_hi,
            (len - Q) > 1 ? len - Q : 1);
        chk(!saw_prot && saw_per, "R2 protected domain spared", {saw_prot, saw_per}, 1);
        chk(rst_cause == 2'b01, "R2 cause", rst_cause, 1);
        chk(man_en, "R7 kept by manual", man_en, 1);
        settle();
      end
    end

    clear_mon();
    @(negedge clk); main_rst_n = 0; man_rst_n = 0;
    repeat (30) @(negedge clk); main_rst_n = 1;
    repeat (5) @(negedge clk); man_rst_n = 1;
    repeat (10) @(negedge clk); #1;
    chk(saw_prot && rst_cause == 2'b00, "R1 main wins over manual", {saw_prot, rst_cause}, 4);
    settle(); write_en(1);

    clear_mon(); fire_wdt(0); repeat (40) @(negedge clk); #1;
    chk(core_hi == Q, "R4 wdt power-on hold", core_hi, Q);
    chk(saw_prot && rst_cause == 2'b10, "R4 wdt power-on type", {saw_prot, rst_cause}, 6);
    chk(!man_en, "R7 cleared by wdt power-on", man_en, 0);
    settle(); write_en(1);

    clear_mon(); fire_wdt(1); repeat (40) @(negedge clk); #1;
    chk(core_hi == Q, "R4 wdt manual hold", core_hi, Q);
    chk(!saw_prot && saw_per && rst_cause == 2'b11, "R4 wdt manual type",
        {saw_prot, saw_per, rst_cause}, 3'b111);
    chk(man_en, "R7 kept by wdt manual", man_en, 1);
    settle();

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule